// File: doc/BRIEF.md
# Flash Page-Program Write Buffer

This unit is the buffered page-program path of a serial NOR flash controller. A small register port lets software do four things. It switches a shared buffer from read-prefetch use into page-program use. It sets a start address. It streams one page of data into the buffer as 32-bit words. It then fires a program command.

On the command, the unit opens a serial frame and shifts it out on a single data line. The frame holds a fixed page-program opcode, then a 3- or 4-byte address, then the whole page in load order. When the last bit has gone, the command bit clears itself. Enabling writes in the flash, erasing, and polling the flash for busy are left to software, which issues those through other paths.

The buffer's use is requested through a configuration bit. The mode actually in force is what that bit reads back. While a page is being sent, the unit holds off both the change of use and any other register update.

Top module: `nor_pp_writer`

## Requirements
- R1: After reset the command bit (offset 0x00, bit 4) reads 0, the buffer-use bit (offset 0x08, bit 0) reads 0, chip select is high and the serial clock is low.
- R2: Writing the buffer-use bit at offset 0x08 bit 0 (1 = page program, 0 = read prefetch) while idle changes its read-back value one clock after the write edge, not at the write edge.
- R3: A buffer-use change written while a frame is in flight does not show in the read-back until the frame has ended. It then takes effect without being written again.
- R4: Each write to the data port (offset 0x0C) stores one 32-bit word. Bits 7:0 are the earliest byte of that word and bits 31:24 the latest, and 32 writes fill the 128-byte page.
- R5: Writing a value with bit 4 set to offset 0x00 while in page-program mode starts a frame at once. Bit 4 of offset 0x00 reads 1 for the whole frame and reads 0 once chip select has returned high.
- R6: A frame carries opcode 0x02, then the address, then the 128 page bytes in load order, each byte sent most significant bit first. Each bit lasts two clocks, with the serial clock low in the first and high in the second. The data line holds steady while the serial clock is high.
- R7: The address bytes are at offsets 0x10 (bits 7:0), 0x14 (bits 15:8), 0x18 (bits 23:16) and 0x24 (bits 31:24), and are sent most significant byte first. Bit 4 of offset 0x04 set selects 4-byte addressing. When it is clear, only the three low bytes are sent.
- R8: A program command written while the buffer is in read-prefetch mode produces no frame, and the command bit reads 0 on the next clock.
- R9: While a frame is in flight, writes to the address bytes, the addressing-mode register, the data port and the command register are ignored.
- R10: After a frame ends, the next data-port write lands in the first word of the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
A command write takes effect on the clock edge where it is sampled. From that edge the command bit reads 1 and chip select is low. The first serial clock rise follows one clock later, and every later bit follows two clocks after the one before. A buffer-use change needs a second edge before it reads back, so the bench reads that bit on both sides of the second edge. Serial bytes are rebuilt by sampling the data line just after each serial clock rise and are compared in order against a queue filled by the driver. The command bit and the frame length are checked on the first clock after chip select rises.

// File: rtl/nor_pp_pkg.sv
package nor_pp_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_CFG  = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;
    localparam logic [7:0] OFS_ADR0 = 8'h10;
    localparam logic [7:0] OFS_ADR1 = 8'h14;
    localparam logic [7:0] OFS_ADR2 = 8'h18;
    localparam logic [7:0] OFS_ADR3 = 8'h24;

    localparam int CMD_PROG_BIT  = 4;
    localparam int MODE_A4_BIT   = 4;
    localparam int CFG_WMODE_BIT = 0;

    localparam logic [7:0] PROG_OPCODE = 8'h02;

    typedef struct packed {
        logic            cmd;
        logic            req_mode;
        logic            eff_mode;
        logic            four_byte;
        logic [3:0][7:0] addr;
    } pp_regs_t;
endpackage

// File: rtl/nor_pp_regs.sv
module nor_pp_regs
    import nor_pp_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          shift_busy,
    input  logic          xfer_done,
    output logic          start,
    output logic          data_we,
    output logic          four_byte,
    output logic [31:0]   flash_addr
);
    pp_regs_t st_d, st_q;
    logic     wr_ok;

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        data_we = 1'b0;
        wr_ok   = reg_we && !st_q.cmd;
        if (reg_we && reg_addr == AW'(OFS_CFG)) begin
            st_d.req_mode = reg_wdata[CFG_WMODE_BIT];
        end
        if (wr_ok) begin
            case (reg_addr)
                AW'(OFS_MODE): st_d.four_byte = reg_wdata[MODE_A4_BIT];
                AW'(OFS_ADR0): st_d.addr[0]   = reg_wdata[7:0];
                AW'(OFS_ADR1): st_d.addr[1]   = reg_wdata[7:0];
                AW'(OFS_ADR2): st_d.addr[2]   = reg_wdata[7:0];
                AW'(OFS_ADR3): st_d.addr[3]   = reg_wdata[7:0];
                AW'(OFS_DATA): data_we        = 1'b1;
                AW'(OFS_CMD): begin
                    if (reg_wdata[CMD_PROG_BIT] && st_q.eff_mode) begin
                        start    = 1'b1;
                        st_d.cmd = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (xfer_done) begin
            st_d.cmd = 1'b0;
        end
        if (!st_q.cmd) begin
            st_d.eff_mode = st_q.req_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            AW'(OFS_CMD):  reg_rdata = DW'(st_q.cmd) << CMD_PROG_BIT;
            AW'(OFS_MODE): reg_rdata = DW'(st_q.four_byte) << MODE_A4_BIT;
            AW'(OFS_CFG):  reg_rdata = DW'(st_q.eff_mode);
            AW'(OFS_ADR0): reg_rdata = DW'(st_q.addr[0]);
            AW'(OFS_ADR1): reg_rdata = DW'(st_q.addr[1]);
            AW'(OFS_ADR2): reg_rdata = DW'(st_q.addr[2]);
            AW'(OFS_ADR3): reg_rdata = DW'(st_q.addr[3]);
            default:       reg_rdata = '0;
        endcase
    end

    assign four_byte  = st_q.four_byte;
    assign flash_addr = st_q.addr;

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd && $past(st_q.cmd)) |-> $stable(st_q.eff_mode));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !shift_busy);

    // R8
    read_mode_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.eff_mode && !st_q.cmd && reg_we && reg_addr == AW'(OFS_CMD)) |=> !st_q.cmd);
endmodule

// File: rtl/nor_pp_buffer.sv
module nor_pp_buffer #(
    parameter int PAGE_BYTES = 128,
    parameter int DW         = 32,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_word,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    localparam int BPW   = DW / 8;
    localparam int WORDS = PAGE_BYTES / BPW;
    localparam int PTR_W = $clog2(WORDS);
    localparam int SEL_W = $clog2(BPW);

    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         ptr;
    } buf_t;

    buf_t        st_d, st_q;
    logic [DW-1:0] word;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.ptr] = wr_word;
            st_d.ptr           = st_q.ptr + PTR_W'(1);
        end
        if (clear) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word    = st_q.mem[rd_idx[IDX_W-1:SEL_W]];
    assign rd_byte = word[8*rd_idx[SEL_W-1:0] +: 8];

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> st_q.ptr == $past(st_q.ptr) + PTR_W'(1));

    // R10
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.ptr == '0);
endmodule

// File: rtl/nor_pp_shifter.sv
module nor_pp_shifter
    import nor_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(PAGE_BYTES + 6)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             four_byte,
    input  logic [31:0]      flash_addr,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_byte,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             active;
        logic             phase;
        logic [2:0]       bitn;
        logic [CNT_W-1:0] byten;
        logic [7:0]       sreg;
    } shf_t;

    shf_t             st_d, st_q;
    logic [CNT_W-1:0] alen, last, k, didx;
    logic [31:0]      ashift;
    logic [7:0]       nbyte;

    always_comb begin
        alen   = four_byte ? CNT_W'(4) : CNT_W'(3);
        last   = alen + CNT_W'(PAGE_BYTES);
        k      = st_q.active ? st_q.byten + CNT_W'(1) : '0;
        ashift = flash_addr >> (8 * (alen - k));
        didx   = k - alen - CNT_W'(1);
        rd_idx = didx[IDX_W-1:0];
        if (k == '0) begin
            nbyte = PROG_OPCODE;
        end else if (k <= alen) begin
            nbyte = ashift[7:0];
        end else begin
            nbyte = rd_byte;
        end
        done = st_q.active && st_q.phase && st_q.bitn == 3'd7 && st_q.byten == last;

        st_d = st_q;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.phase  = 1'b0;
                st_d.bitn   = '0;
                st_d.byten  = '0;
                st_d.sreg   = nbyte;
            end
        end else if (!st_q.phase) begin
            st_d.phase = 1'b1;
        end else begin
            st_d.phase = 1'b0;
            if (st_q.bitn == 3'd7) begin
                if (st_q.byten == last) begin
                    st_d.active = 1'b0;
                    st_d.sreg   = '0;
                end else begin
                    st_d.byten = st_q.byten + CNT_W'(1);
                    st_d.sreg  = nbyte;
                    st_d.bitn  = '0;
                end
            end else begin
                st_d.sreg = {st_q.sreg[6:0], 1'b0};
                st_d.bitn = st_q.bitn + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.phase;
    assign cs_n = !st_q.active;
    assign mosi = st_q.sreg[7];
    assign busy = st_q.active;

    // R6
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cs_n);
endmodule

// File: rtl/nor_pp_writer.sv
module nor_pp_writer
    import nor_pp_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int DW         = 32,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic             start, data_we, four_byte, shift_busy, xfer_done;
    logic [31:0]      flash_addr;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    nor_pp_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shift_busy(shift_busy),
        .xfer_done(xfer_done), .start(start), .data_we(data_we),
        .four_byte(four_byte), .flash_addr(flash_addr)
    );

    nor_pp_buffer #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(data_we), .wr_word(reg_wdata),
        .clear(xfer_done), .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    nor_pp_shifter #(.PAGE_BYTES(PAGE_BYTES)) u_shf (
        .clk(clk), .rst_n(rst_n), .start(start), .four_byte(four_byte),
        .flash_addr(flash_addr), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .busy(shift_busy), .done(xfer_done)
    );
endmodule

// File: tb/tb_nor_pp_writer.sv
module tb_nor_pp_writer;
    import nor_pp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_pp_writer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] pat(input int seed, input int idx);
        return 8'(seed + idx * 7);
    endfunction

    // driver: pushes the expected frame, then loads the page and fires
    task automatic program_page(input logic [31:0] a, input bit four,
                                input bit set_addr, input int seed);
        logic [31:0] rd;
        if (set_addr) begin
            reg_write(OFS_ADR0, {24'h0, a[7:0]});
            reg_write(OFS_ADR1, {24'h0, a[15:8]});
            reg_write(OFS_ADR2, {24'h0, a[23:16]});
            reg_write(OFS_ADR3, {24'h0, a[31:24]});
            reg_write(OFS_MODE, 32'(four) << 4);
        end
        exp_q.push_back(8'h02);
        if (four) exp_q.push_back(a[31:24]);
        exp_q.push_back(a[23:16]);
        exp_q.push_back(a[15:8]);
        exp_q.push_back(a[7:0]);
        for (int w = 0; w < WORDS; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++) begin
                word[8*b +: 8] = pat(seed, 4*w + b);
                exp_q.push_back(pat(seed, 4*w + b));
            end
            reg_write(OFS_DATA, word);
        end
        reg_write(OFS_CMD, 32'h10);
        reg_read(OFS_CMD, rd);
        check(rd == 32'h10, "R5", "command bit right after start", rd, 32'h10);
        check(spi_cs_n == 1'b0, "R5", "chip select low after start", spi_cs_n, 0);
    endtask

    task automatic wait_frame_end();
        logic [31:0] rd;
        @(posedge spi_cs_n);
        @(negedge clk);
        reg_read(OFS_CMD, rd);
        check(rd == 32'h0, "R5", "command bit after frame", rd, 0);
    endtask

    // monitor: rebuild bytes on each serial clock rise and compare
    int bitc = 0;
    logic [7:0] shb = '0;
    initial begin
        forever begin
            @(posedge spi_sclk);
            #1;
            shb = {shb[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected frame byte", shb, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(shb == e, "R6/R7/R4", "frame byte", shb, e);
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge spi_cs_n);
            @(posedge spi_cs_n);
            #1;
            check(bitc == 0 && exp_q.size() == 0, "R6", "frame length leftover",
                  exp_q.size(), 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(OFS_CMD, rd);
        check(rd == 0, "R1", "command bit at reset", rd, 0);
        reg_read(OFS_CFG, rd);
        check(rd == 0, "R1", "buffer use at reset", rd, 0);
        check(spi_cs_n == 1'b1, "R1", "chip select at reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1", "serial clock at reset", spi_sclk, 0);

        // R2 buffer-use change timing
        reg_write(OFS_CFG, 32'h1);
        reg_read(OFS_CFG, rd);
        check(rd == 0, "R2", "buffer use on write edge", rd, 0);
        @(negedge clk);
        reg_read(OFS_CFG, rd);
        check(rd == 1, "R2", "buffer use one clock later", rd, 1);

        // R7 3-byte addressing, R4 word order
        program_page(32'h1234_5678, 1'b0, 1'b1, 3);
        wait_frame_end();

        // R7 4-byte addressing
        program_page(32'hA5C3_0F81, 1'b1, 1'b1, 91);
        wait_frame_end();

        // R9 and R3: writes during a frame
        program_page(32'h77AB_CDEF, 1'b0, 1'b1, 200);
        repeat (40) @(negedge clk);
        reg_write(OFS_ADR0, 32'h11);
        reg_write(OFS_MODE, 32'h10);
        reg_write(OFS_DATA, 32'hDEAD_BEEF);
        reg_write(OFS_DATA, 32'hCAFE_F00D);
        reg_write(OFS_CMD, 32'h10);
        reg_write(OFS_CFG, 32'h0);
        @(negedge clk);
        reg_read(OFS_CFG, rd);
        check(rd == 1, "R3", "buffer use held during frame", rd, 1);
        reg_read(OFS_MODE, rd);
        check(rd == 0, "R9", "mode write ignored during frame", rd, 0);
        reg_read(OFS_ADR0, rd);
        check(rd == 32'hEF, "R9", "address write ignored during frame", rd, 32'hEF);
        wait_frame_end();
        @(negedge clk);
        reg_read(OFS_CFG, rd);
        check(rd == 0, "R3", "deferred buffer use applied", rd, 0);

        // R8 command in read-prefetch mode
        reg_write(OFS_CMD, 32'h10);
        reg_read(OFS_CMD, rd);
        check(rd == 0, "R8", "command bit in read mode", rd, 0);
        begin
            bit low_seen = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!spi_cs_n) low_seen = 1'b1;
            end
            check(!low_seen, "R8", "no frame in read mode", low_seen, 0);
        end

        // R10 and R9: pointer back at word 0, address unchanged
        reg_write(OFS_CFG, 32'h1);
        @(negedge clk);
        program_page(32'h77AB_CDEF, 1'b0, 1'b0, 17);
        wait_frame_end();

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule